// File: doc/BRIEF.md
# Banked GPIO Register File

This block is the register core of a general-purpose I/O controller for 128 pins, organised as four banks of 32. Pin n lives in bank n>>5 at bit n&31. Software reaches it over a simple register bus with an address, write strobe, write data, read strobe and read data. Each bank holds a direction word, an output latch, two alternate-function words, and a copy of the last value written to its set alias.

The output latch never takes a plain write. Software sets bits through a set alias (OR) and clears bits through a clear alias (AND with the inverted value). A pin drives its latch value only while its direction bit marks it as an output.

A level read returns the latch for output pins and the synchronised pin input for input pins. Each level read also raises a one-cycle notification pulse. The fourth bank's level, direction, set and clear words are not contiguous with the other three; they sit 0x100 above the base of their group. The alternate-function words are only stored and read back. Edge detection, interrupts and pad muxing belong to other blocks.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every direction word, output latch, set-alias copy and alternate-function word is zero, so pin_oe and pin_out are all zero.
- R2: Direction words are read/write at byte offsets 0x00C, 0x010, 0x014 (banks 0..2) and 0x10C (bank 3); pin_oe for bank b equals its direction word.
- R3: A write to a set alias (0x018, 0x01C, 0x020, 0x118) ORs the write data into that bank's output latch.
- R4: A write to a clear alias (0x024, 0x028, 0x02C, 0x124) clears the latch bits that are 1 in the write data, and leaves the other bits unchanged.
- R5: pin_out for bank b equals its latch ANDed with its direction word, so an input pin never drives a 1.
- R6: A read of a level word (0x000, 0x004, 0x008, 0x100) returns (latch & dir) | (pin_in & ~dir) for that bank.
- R7: Reading a set alias returns the last value written to it. Reading a clear alias returns the constant 32'hC1EA_0000.
- R8: The alternate-function low words (0x054, 0x05C, 0x064, 0x06C for banks 0..3) and high words (0x058, 0x060, 0x068, 0x070) are plain read/write storage with no effect on the pins.
- R9: Bank 3's level, direction, set and clear words respond only at their 0x1xx offsets. The offset 0x00C + 12 (0x018) belongs to bank 0's set alias, not to bank 3.
- R10: lvl_rd_pulse is high for exactly the one cycle after the clock edge that samples a level read. No other access raises it.
- R11: At byte offsets 0x200 and above, reads return zero without an error, and writes change nothing.
- R12: A read of any unmapped or misaligned offset below 0x200 returns zero and sets bus_err for the one cycle after that read.
- R13: bus_rdata is registered. It takes the read value at the clock edge that samples bus_rd, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle flag for a read of an unmapped offset |
| lvl_rd_pulse | output | 1 | One-cycle pulse after each level read |
| pin_in | input | 128 | Synchronised pin inputs |
| pin_out | output | 128 | Pin output values |
| pin_oe | output | 128 | Pin output enables |

## Verification
The bench targets bank 3's displaced offsets. A decoder that assumed contiguous banks would send those accesses to an unmapped slot and flag an error, or would alias them onto bank 0's set word. Level reads are checked with mixed direction patterns, so a merge with an inverted select returns input bits for output pins. The set and clear aliases are mixed at random against a bench model, so a clear that drops its inversion, or a set that overwrites instead of ORing, shows up on pin_out. The bench also probes 0x200 and above, unmapped holes such as 0x074 and misaligned offsets. A design that faulted on these, flagged them wrongly or let a write land would return nonzero data, raise a wrong bus_err or move the pins.

// File: rtl/gpio_rf_pkg.sv
package gpio_rf_pkg;

  localparam int NBANK  = 4;
  localparam int ADDR_W = 12;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_LEVEL,
    RK_DIR,
    RK_SET,
    RK_CLR,
    RK_AFLO,
    RK_AFHI
  } reg_kind_e;

  localparam logic [ADDR_W-1:0] LEVEL_BASE = 12'h000;
  localparam logic [ADDR_W-1:0] DIR_BASE   = 12'h00C;
  localparam logic [ADDR_W-1:0] SET_BASE   = 12'h018;
  localparam logic [ADDR_W-1:0] CLR_BASE   = 12'h024;
  localparam logic [ADDR_W-1:0] AFLO_BASE  = 12'h054;
  localparam logic [ADDR_W-1:0] AFHI_BASE  = 12'h058;
  localparam logic [ADDR_W-1:0] HIGH_BANK_SHIFT = 12'h100;
  localparam logic [ADDR_W-1:0] WINDOW_END = 12'h200;

  function automatic logic [ADDR_W-1:0] pin_word_off(input int b);
    if (b == NBANK - 1) return HIGH_BANK_SHIFT;
    return ADDR_W'(4 * b);
  endfunction

  function automatic logic [ADDR_W-1:0] af_word_off(input int b);
    return ADDR_W'(8 * b);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_rf_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [1:0]        bank,
  output logic              out_of_window
);

  always_comb begin
    kind = RK_NONE;
    bank = '0;
    out_of_window = (addr >= WINDOW_END);
    for (int b = 0; b < NBANK; b++) begin
      if (addr == LEVEL_BASE + pin_word_off(b)) begin kind = RK_LEVEL; bank = 2'(b); end
      if (addr == DIR_BASE   + pin_word_off(b)) begin kind = RK_DIR;   bank = 2'(b); end
      if (addr == SET_BASE   + pin_word_off(b)) begin kind = RK_SET;   bank = 2'(b); end
      if (addr == CLR_BASE   + pin_word_off(b)) begin kind = RK_CLR;   bank = 2'(b); end
      if (addr == AFLO_BASE  + af_word_off(b))  begin kind = RK_AFLO;  bank = 2'(b); end
      if (addr == AFHI_BASE  + af_word_off(b))  begin kind = RK_AFHI;  bank = 2'(b); end
    end
  end

  always_comb begin
    AST_WINDOW_UNMAPPED: assert (!(out_of_window && kind != RK_NONE)); // R11
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_dir,
  input  logic         wr_set,
  input  logic         wr_clr,
  input  logic         wr_aflo,
  input  logic         wr_afhi,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] setcopy_q,
  output logic [W-1:0] aflo_q,
  output logic [W-1:0] afhi_q,
  output logic [W-1:0] level,
  output logic [W-1:0] drv,
  output logic [W-1:0] oe
);

  logic [W-1:0] dir_d, latch_d, setcopy_d, aflo_d, afhi_d;

  always_comb begin
    dir_d     = wr_dir  ? wdata : dir_q;
    aflo_d    = wr_aflo ? wdata : aflo_q;
    afhi_d    = wr_afhi ? wdata : afhi_q;
    setcopy_d = wr_set  ? wdata : setcopy_q;
    latch_d   = latch_q;
    if (wr_set) latch_d = latch_d | wdata;
    if (wr_clr) latch_d = latch_d & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= '0;
      latch_q   <= '0;
      setcopy_q <= '0;
      aflo_q    <= '0;
      afhi_q    <= '0;
    end else begin
      dir_q     <= dir_d;
      latch_q   <= latch_d;
      setcopy_q <= setcopy_d;
      aflo_q    <= aflo_d;
      afhi_q    <= afhi_d;
    end
  end

  assign level = (latch_q & dir_q) | (pins & ~dir_q);
  assign drv   = latch_q & dir_q;
  assign oe    = dir_q;

  AST_DIR_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata)); // R2
  AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set && !wr_clr) |=> ((latch_q & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !wr_set) |=> ((latch_q & $past(wdata)) == '0)); // R4
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set || wr_clr) |=> $stable(latch_q)); // R3

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_rf_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] CLR_READ_VAL = 32'hC1EA_0000
) (
  input  reg_kind_e                kind,
  input  logic [1:0]               bank,
  input  logic                     out_of_window,
  input  logic [NBANK-1:0][W-1:0]  level_v,
  input  logic [NBANK-1:0][W-1:0]  dir_v,
  input  logic [NBANK-1:0][W-1:0]  setcopy_v,
  input  logic [NBANK-1:0][W-1:0]  aflo_v,
  input  logic [NBANK-1:0][W-1:0]  afhi_v,
  output logic [W-1:0]             rd_val,
  output logic                     is_err,
  output logic                     is_level
);

  always_comb begin
    rd_val   = '0;
    is_err   = 1'b0;
    is_level = 1'b0;
    unique case (kind)
      RK_LEVEL: begin rd_val = level_v[bank]; is_level = 1'b1; end
      RK_DIR:   rd_val = dir_v[bank];
      RK_SET:   rd_val = setcopy_v[bank];
      RK_CLR:   rd_val = CLR_READ_VAL;
      RK_AFLO:  rd_val = aflo_v[bank];
      RK_AFHI:  rd_val = afhi_v[bank];
      default:  is_err = !out_of_window;
    endcase
  end

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_rf_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] CLR_READ_VAL = 32'hC1EA_0000,
  localparam int NPIN = NBANK * W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              bus_err,
  output logic              lvl_rd_pulse,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe
);

  reg_kind_e  kind;
  logic [1:0] bank;
  logic       oow;

  gpio_addr_decode u_dec (
    .addr(bus_addr), .kind(kind), .bank(bank), .out_of_window(oow)
  );

  logic [NBANK-1:0][W-1:0] level_v, dir_v, latch_v, setcopy_v, aflo_v, afhi_v;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr && (bank == 2'(b));
    gpio_bank #(.W(W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_dir   (hit && kind == RK_DIR),
      .wr_set   (hit && kind == RK_SET),
      .wr_clr   (hit && kind == RK_CLR),
      .wr_aflo  (hit && kind == RK_AFLO),
      .wr_afhi  (hit && kind == RK_AFHI),
      .wdata    (bus_wdata),
      .pins     (pin_in[b*W +: W]),
      .dir_q    (dir_v[b]),
      .latch_q  (latch_v[b]),
      .setcopy_q(setcopy_v[b]),
      .aflo_q   (aflo_v[b]),
      .afhi_q   (afhi_v[b]),
      .level    (level_v[b]),
      .drv      (pin_out[b*W +: W]),
      .oe       (pin_oe[b*W +: W])
    );
  end

  logic [W-1:0] rd_val;
  logic         rd_is_err, rd_is_level;

  gpio_read_mux #(.W(W), .CLR_READ_VAL(CLR_READ_VAL)) u_mux (
    .kind(kind), .bank(bank), .out_of_window(oow),
    .level_v(level_v), .dir_v(dir_v), .setcopy_v(setcopy_v),
    .aflo_v(aflo_v), .afhi_v(afhi_v),
    .rd_val(rd_val), .is_err(rd_is_err), .is_level(rd_is_level)
  );

  logic [W-1:0] rdata_d;
  logic         err_d, pulse_d;

  always_comb begin
    rdata_d = bus_rd ? rd_val : bus_rdata;
    err_d   = bus_rd && rd_is_err;
    pulse_d = bus_rd && rd_is_level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= '0;
      bus_err      <= 1'b0;
      lvl_rd_pulse <= 1'b0;
    end else begin
      bus_rdata    <= rdata_d;
      bus_err      <= err_d;
      lvl_rd_pulse <= pulse_d;
    end
  end

  AST_PULSE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_rd_pulse |-> $past(bus_rd)); // R10
  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_rdata == '0); // R12
  AST_HIGH_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= WINDOW_END) |=> (bus_rdata == '0 && !bus_err && !lvl_rd_pulse)); // R11
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R13
  AST_INPUT_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0); // R5

endmodule

// File: tb/tb_gpio_bank_regfile.sv
module tb_gpio_bank_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int NB = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [11:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [W-1:0] bus_wdata, bus_rdata;
  logic bus_err, lvl_rd_pulse;
  logic [NB*W-1:0] pin_in, pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] m_dir [NB];
  logic [W-1:0] m_lat [NB];
  logic [W-1:0] m_set [NB];
  logic [W-1:0] m_alo [NB];
  logic [W-1:0] m_ahi [NB];

  gpio_bank_regfile dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .lvl_rd_pulse(lvl_rd_pulse), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // kinds: 0 level, 1 dir, 2 set, 3 clr, 4 af low, 5 af high
  function automatic logic [11:0] addr_of(input int kind, input int b);
    logic [11:0] pw;
    pw = (b == 3) ? 12'h100 : 12'(4 * b);
    case (kind)
      0: return 12'h000 + pw;
      1: return 12'h00C + pw;
      2: return 12'h018 + pw;
      3: return 12'h024 + pw;
      4: return 12'h054 + 12'(8 * b);
      default: return 12'h058 + 12'(8 * b);
    endcase
  endfunction

  function automatic logic [W-1:0] exp_level(input int b);
    return (m_lat[b] & m_dir[b]) | (pin_in[b*W +: W] & ~m_dir[b]);
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [W-1:0] exp, input logic exp_err,
                    input logic exp_pulse, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    check({tag, " rdata"}, bus_rdata, exp);
    check({tag, " err"}, W'(bus_err), W'(exp_err));
    check({tag, " pulse"}, W'(lvl_rd_pulse), W'(exp_pulse));
  endtask

  task automatic check_pins(input string tag);
    for (int b = 0; b < NB; b++) begin
      check({tag, " pin_oe R2"}, pin_oe[b*W +: W], m_dir[b]);
      check({tag, " pin_out R5"}, pin_out[b*W +: W], m_lat[b] & m_dir[b]);
    end
  endtask

  task automatic model_wr(input int kind, input int b, input logic [W-1:0] d);
    case (kind)
      1: m_dir[b] = d;
      2: begin m_lat[b] = m_lat[b] | d; m_set[b] = d; end
      3: m_lat[b] = m_lat[b] & ~d;
      4: m_alo[b] = d;
      5: m_ahi[b] = d;
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    pin_in = {$urandom, $urandom, $urandom, $urandom};
    for (int b = 0; b < NB; b++) begin
      m_dir[b] = '0; m_lat[b] = '0; m_set[b] = '0; m_alo[b] = '0; m_ahi[b] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_pins("R1 reset");
    for (int b = 0; b < NB; b++) begin
      rd(addr_of(1, b), '0, 1'b0, 1'b0, "R1 dir reset");
      rd(addr_of(2, b), '0, 1'b0, 1'b0, "R1 set copy reset");
      rd(addr_of(4, b), '0, 1'b0, 1'b0, "R1 af low reset");
      rd(addr_of(5, b), '0, 1'b0, 1'b0, "R1 af high reset");
      rd(addr_of(0, b), pin_in[b*W +: W], 1'b0, 1'b1, "R1 R6 level all inputs");
    end

    // R9 bank 3 placement
    wr(12'h10C, 32'hFFFF_0000); model_wr(1, 3, 32'hFFFF_0000);
    wr(12'h118, 32'h00FF_FF00); model_wr(2, 3, 32'h00FF_FF00);
    check_pins("R9 bank3");
    rd(12'h018, m_set[0], 1'b0, 1'b0, "R9 bank0 set untouched");
    rd(12'h100, exp_level(3), 1'b0, 1'b1, "R9 R6 bank3 level");
    wr(12'h124, 32'h0F00_0F00); model_wr(3, 3, 32'h0F00_0F00);
    check_pins("R4 bank3 clear");
    rd(12'h124, 32'hC1EA_0000, 1'b0, 1'b0, "R7 clear read constant");
    rd(12'h118, 32'h00FF_FF00, 1'b0, 1'b0, "R7 set read last");

    // R11 high window
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    check_pins("R11 high write ignored");
    rd(12'h200, '0, 1'b0, 1'b0, "R11 read 0x200");
    rd(12'h30C, '0, 1'b0, 1'b0, "R11 read 0x30C");

    // R12 unmapped holes and misaligned offsets
    rd(12'h074, '0, 1'b1, 1'b0, "R12 hole 0x074");
    rd(12'h002, '0, 1'b1, 1'b0, "R12 misaligned 0x002");
    rd(12'h1FC, '0, 1'b1, 1'b0, "R12 hole 0x1FC");
    wr(12'h074, 32'hFFFF_FFFF);
    check_pins("R12 hole write ignored");

    // R10/R13 pulse length and rdata hold
    rd(12'h004, exp_level(1), 1'b0, 1'b1, "R10 level pulse");
    @(negedge clk);
    check("R10 pulse one cycle", W'(lvl_rd_pulse), '0);
    check("R13 rdata holds", bus_rdata, exp_level(1));
    check("R12 err one cycle", W'(bus_err), '0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int kind, b;
      logic [W-1:0] d;
      kind = int'($urandom_range(0, 5));
      b = int'($urandom_range(0, 3));
      d = $urandom;
      if ($urandom_range(0, 9) == 0) pin_in = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom_range(0, 1) == 0 && kind != 0) begin
        wr(addr_of(kind, b), d);
        model_wr(kind, b, d);
        check_pins("R3 R4 R5 random write");
      end else begin
        case (kind)
          0: rd(addr_of(0, b), exp_level(b), 1'b0, 1'b1, "R6 random level");
          1: rd(addr_of(1, b), m_dir[b], 1'b0, 1'b0, "R2 random dir");
          2: rd(addr_of(2, b), m_set[b], 1'b0, 1'b0, "R7 random set");
          3: rd(addr_of(3, b), 32'hC1EA_0000, 1'b0, 1'b0, "R7 random clear");
          4: rd(addr_of(4, b), m_alo[b], 1'b0, 1'b0, "R8 random af low");
          default: rd(addr_of(5, b), m_ahi[b], 1'b0, 1'b0, "R8 random af high");
        endcase
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule